// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block collects requests from a set of interrupt sources (18 by default) and decides which one, if any, should interrupt the processor. Every source owns a small control register with a pending flag, an enable flag, a routing bit and a 4-bit priority level. A combinational arbiter picks the eligible source with the highest level. That source is offered only when its level is strictly above the level of the service that is running now.

An offered request goes to one of two consumers. Normally the CPU sees it on a request/acknowledge pair, together with its trap number and vector address. If the source's routing bit is set, a transfer engine sees it on its own request/acknowledge pair instead. An acknowledged CPU request raises the running level and saves the old level on an internal 16-entry stack. A return strobe from the CPU pops that stack and restores the saved level.

Software programs the control registers one at a time through a write port. Peripherals raise pending flags through single-cycle set pulses.

Top module: `nest_irq_ctrl`

## Requirements
- R1: While reset is asserted, and for the two cycles after it is released, all request outputs are low, the trap, vector and source outputs are zero, and the running level is 0.
- R2: A write with `cfg_we` high replaces the whole control register of source `cfg_sel`. The fields are: bit 0 pending, bit 1 enable, bit 2 route-to-transfer, bits 6:3 priority. This lets software set or clear a pending flag. A write with `cfg_sel` at or above the source count changes nothing.
- R3: A source is eligible only when its pending flag and its enable flag are both set and its priority is not 0.
- R4: Among eligible sources, the highest priority wins. On a tie, the lowest source index wins.
- R5: The winner is offered only when its priority is strictly greater than `run_prio`. Otherwise both request outputs stay low.
- R6: While `irq_req` is high, `irq_trap` equals 0x18 plus the winner's index, and `irq_vec` equals `irq_trap` times four. While `irq_req` is low, both are zero.
- R7: When `irq_req` and `irq_ack` are both high at a clock edge, the winner's pending flag is cleared, the old `run_prio` is pushed on the stack, and `run_prio` takes the winner's priority.
- R8: A `reti` pulse pops the stack into `run_prio`. If the stack is empty, `run_prio` becomes 0. When `reti` arrives in the same cycle as an accepted CPU acknowledge, the `reti` is ignored.
- R9: A winner with its route bit set raises `xfer_req` with `xfer_src` equal to its index, and never raises `irq_req`. When `xfer_ack` is high at that edge, its pending flag is cleared and `run_prio` is unchanged.
- R10: A `src_set` pulse sets that source's pending flag. If the same source is being cleared by an acceptance in that cycle, the set wins. A configuration write to the same source in that cycle overrides both.
- R11: `irq_ack` or `xfer_ack` with no matching request changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_set | input | N_SRC | Per-source pending-set pulses from peripherals |
| cfg_we | input | 1 | Control register write strobe |
| cfg_sel | input | SEL_W | Source index for the write |
| cfg_wdata | input | 7 | Write data: priority[6:3], route[2], enable[1], pending[0] |
| irq_req | output | 1 | Interrupt offered to the CPU |
| irq_ack | input | 1 | CPU accepts the offered interrupt |
| irq_trap | output | 8 | Trap number of the offered interrupt |
| irq_vec | output | 10 | Vector address of the offered interrupt |
| irq_prio | output | 4 | Priority of the offered interrupt |
| xfer_req | output | 1 | Request offered to the transfer engine |
| xfer_ack | input | 1 | Transfer engine accepts the request |
| xfer_src | output | SEL_W | Source index offered to the transfer engine |
| reti | input | 1 | Return-from-interrupt strobe |
| run_prio | output | 4 | Priority level of the service now running |

## Verification
The bench targets four kinds of corner case.

- **Equal-level requests.** Two sources share the top level, and a second request arrives at the level that is already running. An arbiter using a non-strict compare would pick the higher index. A design using a non-strict preemption test would re-enter the running level.
- **Return handling.** The bench pops the stack past empty and sends `reti` in the same cycle as an acknowledge. A broken stack would return a stale level or lose the pushed one.
- **Clear/set collision.** A peripheral set pulse lands on the same cycle as the acknowledge that clears the flag. A design that lets the clear win would silently drop an event.
- **Routed and stray acknowledges.** Routed sources and acknowledges with nothing pending are mixed in. These expose a design that pushes the stack on a transfer, or that reacts to an unqualified acknowledge.

// File: rtl/nic_pkg.sv
package nic_pkg;
  localparam int PRIO_W = 4;
  localparam int CFG_W  = PRIO_W + 3;

  typedef struct packed {
    logic [PRIO_W-1:0] prio;
    logic              route;
    logic              en;
    logic              pend;
  } src_ctrl_t;
endpackage

// File: rtl/nic_src_regs.sv
module nic_src_regs
  import nic_pkg::*;
#(
  parameter int N_SRC = 18,
  parameter int SEL_W = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_SRC-1:0]        src_set,
  input  logic [N_SRC-1:0]        src_clr,
  input  logic                    cfg_we,
  input  logic [SEL_W-1:0]        cfg_sel,
  input  logic [CFG_W-1:0]        cfg_wdata,
  output src_ctrl_t [N_SRC-1:0]   ctrl_q
);
  src_ctrl_t wr_val;
  assign wr_val = src_ctrl_t'(cfg_wdata);

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    src_ctrl_t nxt;
    logic      wr_hit;

    assign wr_hit = cfg_we && (cfg_sel == SEL_W'(g));

    always_comb begin
      nxt      = ctrl_q[g];
      nxt.pend = (ctrl_q[g].pend & ~src_clr[g]) | src_set[g];
      if (wr_hit) nxt = wr_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl_q[g] <= '0;
      else        ctrl_q[g] <= nxt;
    end
  end
endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter
  import nic_pkg::*;
#(
  parameter int N_SRC = 18,
  parameter int SEL_W = 5
) (
  input  src_ctrl_t [N_SRC-1:0] ctrl,
  output logic                  win_vld,
  output logic [SEL_W-1:0]      win_idx,
  output logic [PRIO_W-1:0]     win_prio,
  output logic                  win_route
);
  always_comb begin
    win_prio  = '0;
    win_idx   = '0;
    win_route = 1'b0;
    for (int i = 0; i < N_SRC; i++) begin
      if (ctrl[i].pend && ctrl[i].en && (ctrl[i].prio > win_prio)) begin
        win_prio  = ctrl[i].prio;
        win_idx   = SEL_W'(i);
        win_route = ctrl[i].route;
      end
    end
    win_vld = (win_prio != '0);
  end
endmodule

// File: rtl/nic_prio_stack.sv
module nic_prio_stack #(
  parameter int DEPTH = 16,
  parameter int W     = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] push_data,
  output logic [W-1:0] top_data
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [W-1:0]     mem_q [DEPTH];
  logic             full;

  assign full = (cnt_q == CNT_W'(DEPTH));

  always_comb begin
    cnt_n = cnt_q;
    if (push && !full)             cnt_n = cnt_q + 1'b1;
    else if (pop && cnt_q != '0)   cnt_n = cnt_q - 1'b1;
  end

  always_comb begin
    top_data = '0;
    for (int j = 0; j < DEPTH; j++)
      if (cnt_q == CNT_W'(j + 1)) top_data = mem_q[j];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    logic slot_we;
    assign slot_we = push && !full && (cnt_q == CNT_W'(s));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mem_q[s] <= '0;
      else if (slot_we) mem_q[s] <= push_data;
    end
  end
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import nic_pkg::*;
#(
  parameter int N_SRC     = 18,
  parameter int SEL_W     = $clog2(N_SRC),
  parameter int STK_DEPTH = 16,
  parameter int TRAP_BASE = 8'h18
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_SRC-1:0]   src_set,
  input  logic               cfg_we,
  input  logic [SEL_W-1:0]   cfg_sel,
  input  logic [6:0]         cfg_wdata,
  output logic               irq_req,
  input  logic               irq_ack,
  output logic [7:0]         irq_trap,
  output logic [9:0]         irq_vec,
  output logic [3:0]         irq_prio,
  output logic               xfer_req,
  input  logic               xfer_ack,
  output logic [SEL_W-1:0]   xfer_src,
  input  logic               reti,
  output logic [3:0]         run_prio
);
  logic [1:0]             rst_sync_q;
  logic                   rst_int_n;
  src_ctrl_t [N_SRC-1:0]  ctrl;
  logic                   win_vld, win_route, offer;
  logic [SEL_W-1:0]       win_idx;
  logic [PRIO_W-1:0]      win_prio, run_q, run_n, stk_top;
  logic                   irq_fire, xfer_fire, pop;
  logic [N_SRC-1:0]       clr_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  nic_src_regs #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .src_set(src_set), .src_clr(clr_vec),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .ctrl_q(ctrl)
  );

  nic_arbiter #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_arb (
    .ctrl(ctrl), .win_vld(win_vld), .win_idx(win_idx),
    .win_prio(win_prio), .win_route(win_route)
  );

  nic_prio_stack #(.DEPTH(STK_DEPTH), .W(PRIO_W)) u_stk (
    .clk(clk), .rst_n(rst_int_n), .push(irq_fire), .pop(pop),
    .push_data(run_q), .top_data(stk_top)
  );

  assign offer     = win_vld && (win_prio > run_q);
  assign irq_req   = offer && !win_route;
  assign xfer_req  = offer && win_route;
  assign irq_fire  = irq_req && irq_ack;
  assign xfer_fire = xfer_req && xfer_ack;
  assign pop       = reti && !irq_fire;

  always_comb begin
    clr_vec = '0;
    if (irq_fire || xfer_fire) clr_vec[win_idx] = 1'b1;
  end

  always_comb begin
    run_n = run_q;
    if (irq_fire) run_n = win_prio;
    else if (pop) run_n = stk_top;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) run_q <= '0;
    else            run_q <= run_n;
  end

  assign irq_trap = irq_req ? (8'(TRAP_BASE) + 8'(win_idx)) : 8'h00;
  assign irq_vec  = {irq_trap, 2'b00};
  assign irq_prio = irq_req ? win_prio : '0;
  assign xfer_src = xfer_req ? win_idx : '0;
  assign run_prio = run_q;
endmodule

// File: rtl/nic_chk.sv
module nic_chk #(
  parameter int N_SRC     = 18,
  parameter int TRAP_BASE = 8'h18
) (
  input logic       clk,
  input logic       rst_n,
  input logic       irq_req,
  input logic       irq_ack,
  input logic [7:0] irq_trap,
  input logic [3:0] irq_prio,
  input logic       xfer_req,
  input logic       xfer_ack,
  input logic       reti,
  input logic [3:0] run_prio
);
  // R5
  strict_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_prio > run_prio));

  // R3
  nonzero_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_prio != 4'd0));

  // R9
  single_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_req, xfer_req}));

  // R6
  trap_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_trap >= 8'(TRAP_BASE) && irq_trap < 8'(TRAP_BASE + N_SRC)));

  // R7
  accept_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_ack) |=> (run_prio == $past(irq_prio)));

  // R9
  xfer_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && xfer_ack && !reti) |=> $stable(run_prio));

  // R8
  reti_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !(irq_req && irq_ack) && run_prio != 4'd0) |=> (run_prio < $past(run_prio)));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_req && !reti) |=> (run_prio == $past(run_prio)));
endmodule

bind nest_irq_ctrl nic_chk #(.N_SRC(N_SRC), .TRAP_BASE(TRAP_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_ack(irq_ack),
  .irq_trap(irq_trap), .irq_prio(irq_prio), .xfer_req(xfer_req),
  .xfer_ack(xfer_ack), .reti(reti), .run_prio(run_prio)
);

// File: tb/sim_nest_irq_ctrl.sv
module sim_nest_irq_ctrl;
  localparam int N = 18;
  localparam int SW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  src_set = '0;
  logic          cfg_we = 1'b0;
  logic [SW-1:0] cfg_sel = '0;
  logic [6:0]    cfg_wdata = '0;
  logic          irq_ack = 1'b0, xfer_ack = 1'b0, reti = 1'b0;
  logic          irq_req, xfer_req;
  logic [7:0]    irq_trap;
  logic [9:0]    irq_vec;
  logic [3:0]    irq_prio, run_prio;
  logic [SW-1:0] xfer_src;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  // reference state
  bit m_pend [N]; bit m_en [N]; bit m_rt [N]; int m_pr [N];
  int m_run = 0;
  int m_stk [$];

  always #2.5 clk = ~clk;

  nest_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .src_set(src_set), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .irq_req(irq_req),
    .irq_ack(irq_ack), .irq_trap(irq_trap), .irq_vec(irq_vec),
    .irq_prio(irq_prio), .xfer_req(xfer_req), .xfer_ack(xfer_ack),
    .xfer_src(xfer_src), .reti(reti), .run_prio(run_prio)
  );

  function automatic logic [6:0] cw(int p, bit rt, bit en, bit pd);
    return 7'(p * 8 + rt * 4 + en * 2 + pd);
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // winner of the model: -1 if none
  function automatic int m_win();
    int bi = -1, bp = 0;
    for (int i = 0; i < N; i++)
      if (m_pend[i] && m_en[i] && m_pr[i] > bp) begin bp = m_pr[i]; bi = i; end
    return bi;
  endfunction

  task automatic compare();
    int w = m_win();
    bit off = (w >= 0) && (m_pr[w] > m_run);
    bit ei = off && !m_rt[w];
    bit ex = off && m_rt[w];
    chk("R5 irq_req", int'(irq_req), int'(ei));
    chk("R9 xfer_req", int'(xfer_req), int'(ex));
    chk("R4/R6 irq_trap", int'(irq_trap), ei ? 24 + w : 0);
    chk("R6 irq_vec", int'(irq_vec), ei ? (24 + w) * 4 : 0);
    chk("R4 irq_prio", int'(irq_prio), ei ? m_pr[w] : 0);
    chk("R9 xfer_src", int'(xfer_src), ex ? w : 0);
    chk("R7/R8 run_prio", int'(run_prio), m_run);
  endtask

  task automatic model_step();
    int w = m_win();
    bit off = (w >= 0) && (m_pr[w] > m_run);
    bit ifire = off && !m_rt[w] && irq_ack;
    bit xfire = off && m_rt[w] && xfer_ack;
    if (ifire) begin
      if (m_stk.size() < 16) m_stk.push_back(m_run);
      m_run = m_pr[w];
    end else if (reti) begin
      m_run = (m_stk.size() > 0) ? m_stk.pop_back() : 0;
    end
    for (int i = 0; i < N; i++) begin
      if ((ifire || xfire) && i == w) m_pend[i] = 0;
      if (src_set[i]) m_pend[i] = 1;
      if (cfg_we && int'(cfg_sel) == i) begin
        m_pend[i] = cfg_wdata[0]; m_en[i] = cfg_wdata[1];
        m_rt[i] = cfg_wdata[2]; m_pr[i] = int'(cfg_wdata[6:3]);
      end
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
    src_set = '0; cfg_we = 0; irq_ack = 0; xfer_ack = 0; reti = 0;
  endtask

  task automatic wr(int sel, logic [6:0] d);
    cfg_we = 1; cfg_sel = SW'(sel); cfg_wdata = d;
    cyc();
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_pend[i] = 0; m_en[i] = 0; m_rt[i] = 0; m_pr[i] = 0; end
    repeat (4) @(negedge clk);
    // R1: outputs quiet while held in reset
    chk("R1 irq_req in reset", int'(irq_req), 0);
    chk("R1 run_prio in reset", int'(run_prio), 0);
    rst_n = 1;
    // R1: write during synchroniser window is ignored
    cfg_we = 1; cfg_sel = 0; cfg_wdata = cw(5, 0, 1, 1);
    @(negedge clk);
    cfg_we = 0;
    repeat (2) @(negedge clk);
    chk("R1 irq_req after release", int'(irq_req), 0);
    compare();

    // R2, R6: software-pended source 3, level 5
    wr(3, cw(5, 0, 1, 1));
    chk("R6 trap src3", int'(irq_trap), 8'h1B);
    chk("R6 vec src3", int'(irq_vec), 10'h06C);
    // R4: tie at level 7 between 5 and 2 goes to 2
    wr(5, cw(7, 0, 1, 1));
    wr(2, cw(7, 0, 1, 1));
    chk("R4 tie lowest index", int'(irq_trap), 8'h1A);
    // R7: accept
    irq_ack = 1; cyc();
    chk("R7 run raised", int'(run_prio), 7);
    // R5: equal level may not preempt
    chk("R5 equal level held", int'(irq_req), 0);
    // R6: level 9 on source 17
    wr(17, cw(9, 0, 1, 1));
    chk("R6 trap src17", int'(irq_trap), 8'h29);
    chk("R6 vec src17", int'(irq_vec), 10'h0A4);
    irq_ack = 1; cyc();
    chk("R7 nested run", int'(run_prio), 9);
    reti = 1; cyc();
    chk("R8 pop to 7", int'(run_prio), 7);
    reti = 1; cyc();
    chk("R8 pop to 0", int'(run_prio), 0);
    chk("R4 src5 offered", int'(irq_trap), 8'h1D);
    // R8: reti with accepted ack is ignored
    irq_ack = 1; reti = 1; cyc();
    chk("R8 ack beats reti", int'(run_prio), 7);
    reti = 1; cyc();
    reti = 1; cyc();
    chk("R8 empty pop", int'(run_prio), 0);
    // R3: level 0 and disabled sources never offered
    wr(3, cw(0, 0, 1, 1));
    chk("R3 level zero", int'(irq_req), 0);
    wr(3, cw(5, 0, 0, 1));
    chk("R3 disabled", int'(irq_req), 0);
    // R9: routed source
    wr(4, cw(6, 1, 1, 1));
    chk("R9 xfer_req", int'(xfer_req), 1);
    chk("R9 xfer_src", int'(xfer_src), 4);
    chk("R9 no irq", int'(irq_req), 0);
    xfer_ack = 1; cyc();
    chk("R9 run unchanged", int'(run_prio), 0);
    chk("R9 flag cleared", int'(xfer_req), 0);
    // R11: stray acks
    irq_ack = 1; xfer_ack = 1; cyc();
    chk("R11 stray ack", int'(run_prio), 0);
    // R10: set beats clear on accept
    wr(6, cw(2, 0, 1, 1));
    irq_ack = 1; src_set[6] = 1; cyc();
    reti = 1; cyc();
    chk("R10 set survives clear", int'(irq_trap), 8'h1E);
    // R2: software clear, then hardware set
    wr(6, cw(2, 0, 1, 0));
    chk("R2 soft clear", int'(irq_req), 0);
    src_set[6] = 1; cyc();
    chk("R10 hw set", int'(irq_req), 1);
    // R10: write overrides set
    src_set[6] = 1; wr(6, cw(2, 0, 1, 0));
    chk("R10 write overrides", int'(irq_req), 0);
    // R2: out-of-range select
    wr(20, cw(15, 0, 1, 1));
    chk("R2 bad select", int'(irq_req), 0);

    // random traffic
    for (int k = 0; k < 4000; k++) begin
      if ($urandom_range(0, 3) == 0) begin
        cfg_we = 1; cfg_sel = SW'($urandom_range(0, 19));
        cfg_wdata = 7'($urandom_range(0, 127));
      end
      for (int i = 0; i < N; i++) src_set[i] = ($urandom_range(0, 15) == 0);
      irq_ack  = ($urandom_range(0, 1) == 0);
      xfer_ack = ($urandom_range(0, 1) == 0);
      reti     = ($urandom_range(0, 7) == 0);
      cyc();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule